// File: doc/BRIEF.md
# TLB Management Register Interface

This block holds the registers that software uses to maintain a software-managed translation lookaside buffer, together with the entry storage itself. Each entry has a tag word, a data word and an 8-bit owner ID. Software reaches six registers over a simple bus with a write strobe, a read strobe, a register select and write data. The registers are an entry index, a tag window, a data window, a process ID, a zone-protection word and a search trigger. The tag and data windows act on the entry that the index register selects. Writing the search register runs an associative lookup of all entries through a combinational compare block. The result is recorded in the index register.

The block also tells a downstream translation cache when its cached state may be stale. A one-hot or multi-bit per-entry flush mask pulses when an entry is overwritten or when the process ID changes. A single flush-all pulse follows a change of the zone word. Two static configuration inputs set how much of the interface is usable: whether the MMU exists at all, and the access level.

Register select encoding: 0 index, 1 data, 2 tag, 3 search, 4 process ID, 5 zone; 6 and 7 are unused. The select's least significant bit separates the data window (1) from the tag window (2). Tag word fields: page number in bits 31:10, size code in bits 9:7 (page of 2^(10+2*code) bytes), valid in bit 6. Data word: zone number in bits 7:4. Zone z owns the 2-bit code at zone-word bits 31-2z and 30-2z.

Top module: `tlb_mgmt_regs`

## Requirements
- R1: After synchronous reset, every register (index, process ID, zone, all entry tag, data and ID fields) is zero. Every read returns 0, and busy, flush_all and flush_mask are low.
- R2: Data and tag window accesses use the entry given by the low log2(ENTRIES) bits of the index register. Read data appears on rdata in the cycle after the read strobe and is 0 in every other cycle. A cycle with both strobes performs only the write.
- R3: A tag window write stores the word and copies process ID bits 7:0 into that entry's ID field.
- R4: A tag window read returns the tag word and replaces the process ID register with the entry's stored ID, zero-extended.
- R5: A search write compares wdata bits 31:10 against every valid entry's page number, masked by that entry's page size. On a hit, the lowest matching entry index is written to the index register, with all upper bits cleared.
- R6: On a search miss, index bit 31 is set and the other index bits are kept.
- R7: An entry with ID 0 matches under any process ID. An entry with a nonzero ID matches only when it equals process ID bits 7:0.
- R8: In a search, an entry whose zone code is 00 is skipped while user_mode is 1. Any other code, or user_mode 0, lets the entry match. Zone numbers at or above ZONES count as code 01.
- R9: A zone write whose value differs from the current zone word raises flush_all for exactly one cycle after the write. Writing the same value raises nothing.
- R10: A process ID write that changes the value sets flush_mask bits in the next cycle. The bits set are those of valid entries whose nonzero ID equals the old ID bits 7:0.
- R11: A tag write sets flush_mask for that entry for one cycle after the write, but only if the entry's previous tag was valid.
- R12: With cfg_mmu below 2 or cfg_access 0, reads return 0 and writes are ignored. Data, tag, process ID and zone reads return 0 unless cfg_access bit 0 is 1. Process ID, zone and search writes are ignored unless cfg_access is 2 or 3.
- R13: A search write raises busy for exactly one cycle, and the index is updated at the end of that cycle. Any read or write presented while busy is dropped, and its rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mmu | input | 2 | MMU presence level, static; below 2 disables the interface |
| cfg_access | input | 2 | Access level, static; bit 0 read enable, 2 or 3 full write access |
| user_mode | input | 1 | Privilege of the searching context, sampled in the busy cycle |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register select |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| busy | output | 1 | Search in progress |
| flush_all | output | 1 | Whole-cache flush pulse |
| flush_mask | output | ENTRIES | Per-entry flush pulse mask |

## Verification
Read data, flush_all and flush_mask are all due one clock after the strobe that causes them. Busy also rises one clock after a search write, and the search result reaches the index register one clock after busy, so it can be read back no earlier than the third cycle after the search. The bench drives strobes on the falling edge and compares every output against its own model on every falling edge. The directed read-back and flush checks sample exactly one falling edge after the strobe cycle.

// File: rtl/tlb_mgmt_pkg.sv
package tlb_mgmt_pkg;

    localparam int WORD_W    = 32;
    localparam int TID_W     = 8;
    localparam int VALID_POS = 6;
    localparam int SIZE_LSB  = 7;
    localparam int EPN_LSB   = 10;
    localparam int ZSEL_LSB  = 4;
    localparam int MISS_POS  = 31;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [TID_W-1:0]  tid_t;

    typedef enum logic [2:0] {
        SEL_INDEX  = 3'd0,
        SEL_DATA   = 3'd1,
        SEL_TAG    = 3'd2,
        SEL_SEARCH = 3'd3,
        SEL_PID    = 3'd4,
        SEL_ZONE   = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic live;
        logic may_read;
        logic may_full;
    } access_t;

    typedef struct packed {
        logic     wr;
        logic     rd;
        reg_sel_e sel;
        word_t    data;
    } bus_req_t;

    function automatic access_t decode_access(logic [1:0] mmu_lvl, logic [1:0] acc_lvl);
        access_t a;
        a.live     = (mmu_lvl >= 2'd2) && (acc_lvl != 2'd0);
        a.may_read = a.live && acc_lvl[0];
        a.may_full = a.live && acc_lvl[1];
        return a;
    endfunction

    function automatic logic [4:0] page_shift(logic [2:0] code);
        return 5'd10 + {1'b0, code, 1'b0};
    endfunction

    function automatic word_t page_mask(logic [2:0] code);
        return {WORD_W{1'b1}} << page_shift(code);
    endfunction

    function automatic logic [1:0] zone_code(word_t zword, logic [3:0] znum);
        word_t s;
        s = zword >> (5'd30 - {znum, 1'b0});
        return s[1:0];
    endfunction

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
    import tlb_mgmt_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int EW      = $clog2(ENTRIES)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we_tag,
    input  logic                      we_data,
    input  logic [EW-1:0]             w_idx,
    input  word_t                     w_word,
    input  tid_t                      w_tid,
    output word_t [ENTRIES-1:0]       tag_arr,
    output word_t [ENTRIES-1:0]       data_arr,
    output tid_t  [ENTRIES-1:0]       tid_arr
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                tag_arr[g]  <= '0;
                data_arr[g] <= '0;
                tid_arr[g]  <= '0;
            end else if (w_idx == EW'(g)) begin
                if (we_tag) begin
                    tag_arr[g] <= w_word;
                    tid_arr[g] <= w_tid;
                end
                if (we_data) begin
                    data_arr[g] <= w_word;
                end
            end
        end
    end

    // R3: the owner ID captured with a tag write is the ID supplied with it
    assert_tid_latch_R3: assert property (@(posedge clk) disable iff (rst)
        we_tag |=> (tid_arr[$past(w_idx)] == $past(w_tid)));

endmodule

// File: rtl/tlb_search_match.sv
module tlb_search_match
    import tlb_mgmt_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int ZONES   = 16,
    parameter int EW      = $clog2(ENTRIES)
) (
    input  word_t [ENTRIES-1:0] tag_arr,
    input  word_t [ENTRIES-1:0] data_arr,
    input  tid_t  [ENTRIES-1:0] tid_arr,
    input  word_t               vaddr,
    input  tid_t                pid8,
    input  word_t               zword,
    input  logic                user_mode,
    output logic                hit,
    output logic [EW-1:0]       hit_idx
);

    logic [ENTRIES-1:0] cand;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        word_t      msk;
        logic [3:0] znum;
        logic [1:0] zc;
        logic       page_eq, id_ok, zone_ok;

        always_comb begin
            msk     = page_mask(tag_arr[g][SIZE_LSB+2:SIZE_LSB]);
            page_eq = ((vaddr ^ tag_arr[g]) & msk) == '0;
            id_ok   = (tid_arr[g] == '0) || (tid_arr[g] == pid8);
            znum    = data_arr[g][ZSEL_LSB+3:ZSEL_LSB];
            zc      = ({1'b0, znum} >= 5'(ZONES)) ? 2'b01 : zone_code(zword, znum);
            zone_ok = !((zc == 2'b00) && user_mode);
            cand[g] = tag_arr[g][VALID_POS] && page_eq && id_ok && zone_ok;
        end
    end

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (cand[i]) begin
                hit     = 1'b1;
                hit_idx = EW'(i);
            end
        end
    end

endmodule

// File: rtl/tlb_flush_gen.sv
module tlb_flush_gen
    import tlb_mgmt_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int EW      = $clog2(ENTRIES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tag_wr,
    input  logic [EW-1:0]       tag_idx,
    input  logic                pid_chg,
    input  tid_t                old_pid8,
    input  logic                zone_chg,
    input  word_t [ENTRIES-1:0] tag_arr,
    input  tid_t  [ENTRIES-1:0] tid_arr,
    output logic                flush_all,
    output logic [ENTRIES-1:0]  flush_mask
);

    logic [ENTRIES-1:0] mask_nxt;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_sel
        logic live, by_tag, by_pid;
        always_comb begin
            live        = tag_arr[g][VALID_POS];
            by_tag      = tag_wr && (tag_idx == EW'(g));
            by_pid      = pid_chg && (tid_arr[g] != '0) && (tid_arr[g] == old_pid8);
            mask_nxt[g] = live && (by_tag || by_pid);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flush_all  <= 1'b0;
            flush_mask <= '0;
        end else begin
            flush_all  <= zone_chg;
            flush_mask <= mask_nxt;
        end
    end

    // R9: a whole-cache flush only follows a changing zone write
    assert_zone_flush_cause_R9: assert property (@(posedge clk) disable iff (rst)
        flush_all |-> $past(zone_chg));

    // R11: an entry rewrite flushes at most one entry
    assert_tag_flush_single_R11: assert property (@(posedge clk) disable iff (rst)
        tag_wr |=> ($countones(flush_mask) <= 1));

    // R10: per-entry flushes have a tag write or a process ID change behind them
    assert_mask_cause_R10: assert property (@(posedge clk) disable iff (rst)
        (flush_mask != '0) |-> $past(tag_wr || pid_chg));

endmodule

// File: rtl/tlb_mgmt_regs.sv
module tlb_mgmt_regs
    import tlb_mgmt_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int ZONES   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         cfg_mmu,
    input  logic [1:0]         cfg_access,
    input  logic               user_mode,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [2:0]         addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    output logic               busy,
    output logic               flush_all,
    output logic [ENTRIES-1:0] flush_mask
);

    localparam int EW = $clog2(ENTRIES);
    localparam word_t EPN_MASK = {WORD_W{1'b1}} << EPN_LSB;

    access_t  acc;
    bus_req_t req;
    word_t    idx_q, pid_q, zone_q, sv_q, rdata_q, rd_mux;
    logic     busy_q;
    logic [EW-1:0] sel_idx, hit_idx;
    logic     hit;
    logic     wr_ok, rd_ok, tag_we, data_we, srch_go, pid_we, pid_chg, zone_we, zone_chg, tag_rd;

    word_t [ENTRIES-1:0] tag_arr, data_arr;
    tid_t  [ENTRIES-1:0] tid_arr;

    always_comb begin
        acc      = decode_access(cfg_mmu, cfg_access);
        req.wr   = wr_en;
        req.rd   = rd_en;
        req.sel  = reg_sel_e'(addr);
        req.data = wdata;
        sel_idx  = idx_q[EW-1:0];
        wr_ok    = acc.live && !busy_q && req.wr;
        rd_ok    = acc.live && !busy_q && req.rd && !req.wr;
        tag_we   = wr_ok && (req.sel == SEL_TAG);
        data_we  = wr_ok && (req.sel == SEL_DATA);
        srch_go  = wr_ok && acc.may_full && (req.sel == SEL_SEARCH);
        pid_we   = wr_ok && acc.may_full && (req.sel == SEL_PID);
        pid_chg  = pid_we && (req.data != pid_q);
        zone_we  = wr_ok && acc.may_full && (req.sel == SEL_ZONE);
        zone_chg = zone_we && (req.data != zone_q);
        tag_rd   = rd_ok && acc.may_read && (req.sel == SEL_TAG);
    end

    always_comb begin
        rd_mux = '0;
        case (req.sel)
            SEL_INDEX: rd_mux = idx_q;
            SEL_DATA:  rd_mux = acc.may_read ? data_arr[sel_idx] : '0;
            SEL_TAG:   rd_mux = acc.may_read ? tag_arr[sel_idx]  : '0;
            SEL_PID:   rd_mux = acc.may_read ? pid_q  : '0;
            SEL_ZONE:  rd_mux = acc.may_read ? zone_q : '0;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q   <= '0;
            pid_q   <= '0;
            zone_q  <= '0;
            sv_q    <= '0;
            busy_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            rdata_q <= rd_ok ? rd_mux : '0;
            busy_q  <= srch_go;
            if (srch_go) begin
                sv_q <= req.data & EPN_MASK;
            end
            if (busy_q) begin
                if (hit) begin
                    idx_q <= {{(WORD_W-EW){1'b0}}, hit_idx};
                end else begin
                    idx_q[MISS_POS] <= 1'b1;
                end
            end else if (wr_ok && (req.sel == SEL_INDEX)) begin
                idx_q <= req.data;
            end
            if (pid_we) begin
                pid_q <= req.data;
            end else if (tag_rd) begin
                pid_q <= {{(WORD_W-TID_W){1'b0}}, tid_arr[sel_idx]};
            end
            if (zone_we) begin
                zone_q <= req.data;
            end
        end
    end

    tlb_entry_store #(.ENTRIES(ENTRIES), .EW(EW)) u_store (
        .clk      (clk),
        .rst      (rst),
        .we_tag   (tag_we),
        .we_data  (data_we),
        .w_idx    (sel_idx),
        .w_word   (req.data),
        .w_tid    (pid_q[TID_W-1:0]),
        .tag_arr  (tag_arr),
        .data_arr (data_arr),
        .tid_arr  (tid_arr)
    );

    tlb_search_match #(.ENTRIES(ENTRIES), .ZONES(ZONES), .EW(EW)) u_match (
        .tag_arr   (tag_arr),
        .data_arr  (data_arr),
        .tid_arr   (tid_arr),
        .vaddr     (sv_q),
        .pid8      (pid_q[TID_W-1:0]),
        .zword     (zone_q),
        .user_mode (user_mode),
        .hit       (hit),
        .hit_idx   (hit_idx)
    );

    tlb_flush_gen #(.ENTRIES(ENTRIES), .EW(EW)) u_flush (
        .clk        (clk),
        .rst        (rst),
        .tag_wr     (tag_we),
        .tag_idx    (sel_idx),
        .pid_chg    (pid_chg),
        .old_pid8   (pid_q[TID_W-1:0]),
        .zone_chg   (zone_chg),
        .tag_arr    (tag_arr),
        .tid_arr    (tid_arr),
        .flush_all  (flush_all),
        .flush_mask (flush_mask)
    );

    assign rdata = rdata_q;
    assign busy  = busy_q;

    // R13: busy never lasts beyond one cycle
    assert_busy_one_cycle_R13: assert property (@(posedge clk) disable iff (rst)
        busy_q |=> !busy_q);

    // R6: a failed search leaves the miss flag set in the index
    assert_miss_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !hit) |=> idx_q[MISS_POS]);

    // R5: a successful search leaves exactly the matched index
    assert_hit_index_R5: assert property (@(posedge clk) disable iff (rst)
        (busy_q && hit) |=> (idx_q == {{(WORD_W-EW){1'b0}}, $past(hit_idx)}));

    // R12: a disabled interface only ever reads zero
    assert_disabled_zero_R12: assert property (@(posedge clk) disable iff (rst)
        !acc.live |=> (rdata_q == '0));

endmodule

// File: tb/tlb_mgmt_regs_test.sv
`timescale 1ns/1ps
module tlb_mgmt_regs_test;

    localparam int N  = 64;
    localparam int NZ = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   cfg_mmu = 2'd3;
    logic [1:0]   cfg_access = 2'd3;
    logic         user_mode = 1'b0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [2:0]   addr = 3'd0;
    logic [31:0]  wdata = 32'd0;
    logic [31:0]  rdata;
    logic         busy;
    logic         flush_all;
    logic [N-1:0] flush_mask;

    int    checks = 0;
    int    fails = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    tlb_mgmt_regs #(.ENTRIES(N), .ZONES(NZ)) uut (
        .clk(clk), .rst(rst), .cfg_mmu(cfg_mmu), .cfg_access(cfg_access),
        .user_mode(user_mode), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .busy(busy), .flush_all(flush_all),
        .flush_mask(flush_mask)
    );

    // ---------------- behavioural reference model ----------------
    bit [31:0] m_tag [N];
    bit [31:0] m_data[N];
    bit [7:0]  m_tid [N];
    bit [31:0] m_idx, m_pid, m_zone, m_sv, e_rd;
    bit        m_busy, e_all;
    bit [N-1:0] e_mask;

    function automatic int model_search(bit [31:0] va, bit usr);
        for (int i = 0; i < N; i++) begin
            bit [31:0] t = m_tag[i];
            int sh, z, code;
            if (!t[6]) continue;
            sh = 10 + 2 * int'(t[9:7]);
            if ((va >> sh) != (t >> sh)) continue;
            if (m_tid[i] != 0 && m_tid[i] != m_pid[7:0]) continue;
            z = int'(m_data[i][7:4]);
            code = int'((m_zone >> (30 - 2 * z)) & 32'h3);
            if (z >= NZ) code = 1;
            if (code == 0 && usr) continue;
            return i;
        end
        return -1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                m_tag[i] = 0; m_data[i] = 0; m_tid[i] = 0;
            end
            m_idx = 0; m_pid = 0; m_zone = 0; m_sv = 0; m_busy = 0;
            e_rd = 0; e_all = 0; e_mask = 0;
        end else begin
            bit live, rdok, full;
            int e, h;
            live = (cfg_mmu >= 2) && (cfg_access != 0);
            rdok = live && cfg_access[0];
            full = live && cfg_access[1];
            e = int'(m_idx % N);
            e_rd = 0; e_all = 0; e_mask = 0;
            if (m_busy) begin
                h = model_search(m_sv, user_mode);
                if (h >= 0) m_idx = h;
                else m_idx[31] = 1'b1;
                m_busy = 0;
            end else if (live && wr_en) begin
                case (addr)
                    3'd0: m_idx = wdata;
                    3'd1: m_data[e] = wdata;
                    3'd2: begin
                        if (m_tag[e][6]) e_mask[e] = 1'b1;
                        m_tid[e] = m_pid[7:0];
                        m_tag[e] = wdata;
                    end
                    3'd3: if (full) begin m_sv = wdata & 32'hFFFF_FC00; m_busy = 1; end
                    3'd4: if (full && wdata != m_pid) begin
                        for (int i = 0; i < N; i++)
                            if (m_tag[i][6] && m_tid[i] != 0 && m_tid[i] == m_pid[7:0]) e_mask[i] = 1'b1;
                        m_pid = wdata;
                    end
                    3'd5: if (full && wdata != m_zone) begin e_all = 1; m_zone = wdata; end
                    default: ;
                endcase
            end else if (live && rd_en) begin
                case (addr)
                    3'd0: e_rd = m_idx;
                    3'd1: e_rd = rdok ? m_data[e] : 0;
                    3'd2: if (rdok) begin e_rd = m_tag[e]; m_pid = {24'd0, m_tid[e]}; end
                    3'd4: e_rd = rdok ? m_pid : 0;
                    3'd5: e_rd = rdok ? m_zone : 0;
                    default: e_rd = 0;
                endcase
            end
        end
    end

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(rdata == e_rd, cur_req, "rdata(model)", 64'(rdata), 64'(e_rd));
            check(busy == m_busy, "R13", "busy(model)", 64'(busy), 64'(m_busy));
            check(flush_all == e_all, "R9", "flush_all(model)", 64'(flush_all), 64'(e_all));
            check(flush_mask == e_mask, "R10/R11", "flush_mask(model)", 64'(flush_mask), 64'(e_mask));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1; rd_en = 0; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic wr_fl(input logic [2:0] a, input logic [31:0] d,
                         input bit x_all, input logic [N-1:0] x_mask, input string req);
        wr(a, d);
        check(flush_all == x_all, req, "flush_all", 64'(flush_all), 64'(x_all));
        check(flush_mask == x_mask, req, "flush_mask", 64'(flush_mask), 64'(x_mask));
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] x, input string req);
        @(negedge clk); rd_en = 1; wr_en = 0; addr = a;
        @(negedge clk); rd_en = 0;
        check(rdata == x, req, "rdata", 64'(rdata), 64'(x));
    endtask

    task automatic srch(input logic [31:0] va);
        wr(3'd3, va);
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: run did not complete");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        cur_req = "R1";
        check(rdata == 0 && busy == 0 && flush_all == 0 && flush_mask == 0, "R1",
              "outputs after reset", 64'(rdata), 64'd0);
        rd(3'd0, 32'd0, "R1"); rd(3'd1, 32'd0, "R1"); rd(3'd2, 32'd0, "R1");
        rd(3'd4, 32'd0, "R1"); rd(3'd5, 32'd0, "R1");

        // R2: index-selected data window, low index bits only
        cur_req = "R2";
        wr(3'd0, 32'd3);
        wr(3'd1, 32'h1234_0F10);
        rd(3'd1, 32'h1234_0F10, "R2");
        wr(3'd0, 32'h0000_0043);
        rd(3'd1, 32'h1234_0F10, "R2");
        rd(3'd0, 32'h0000_0043, "R2");
        @(negedge clk); wr_en = 1; rd_en = 1; addr = 3'd0; wdata = 32'd3;
        @(negedge clk); wr_en = 0; rd_en = 0;
        check(rdata == 0, "R2", "rdata on write+read", 64'(rdata), 64'd0);
        rd(3'd0, 32'd3, "R2");

        // R3/R4: tag write latches ID, tag read restores it to the PID
        cur_req = "R3";
        wr(3'd4, 32'h0000_01A5);
        wr_fl(3'd2, 32'h0000_40C0, 1'b0, '0, "R11");
        wr(3'd4, 32'h0000_0007);
        cur_req = "R4";
        rd(3'd2, 32'h0000_40C0, "R4");
        rd(3'd4, 32'h0000_00A5, "R3");

        // global 16K entry 5 in zone 0
        cur_req = "R7";
        wr(3'd0, 32'd5);
        wr(3'd4, 32'd0);
        wr(3'd1, 32'd0);
        wr(3'd2, 32'h0000_8140);

        // R5/R6: searches with page-size masking
        cur_req = "R5";
        wr(3'd4, 32'h0000_00A5);
        srch(32'h0000_4ABC); rd(3'd0, 32'd3, "R5");
        srch(32'h0000_4FFF); rd(3'd0, 32'd3, "R5");
        cur_req = "R6";
        srch(32'h0000_5000); rd(3'd0, 32'h8000_0003, "R6");
        cur_req = "R7";
        srch(32'h0000_9FFF); rd(3'd0, 32'd5, "R7");
        wr(3'd4, 32'h0000_0011);
        srch(32'h0000_4ABC); rd(3'd0, 32'h8000_0005, "R7");

        // R8: zone code 00 blocks user-mode searches
        cur_req = "R8";
        srch(32'h0000_8000); rd(3'd0, 32'd5, "R8");
        user_mode = 1;
        srch(32'h0000_8000); rd(3'd0, 32'h8000_0005, "R8");
        cur_req = "R9";
        wr_fl(3'd5, 32'hC000_0000, 1'b1, '0, "R9");
        wr_fl(3'd5, 32'hC000_0000, 1'b0, '0, "R9");
        cur_req = "R8";
        srch(32'h0000_8000); rd(3'd0, 32'd5, "R8");
        user_mode = 0;

        // R10: process ID change flushes entries owned by the old ID
        cur_req = "R10";
        wr_fl(3'd4, 32'h0000_00A5, 1'b0, '0, "R10");
        wr_fl(3'd4, 32'h0000_0022, 1'b0, N'(1) << 3, "R10");
        wr_fl(3'd4, 32'h0000_0022, 1'b0, '0, "R10");

        // R11: tag rewrite flushes only previously valid entries
        cur_req = "R11";
        wr(3'd0, 32'd3);
        wr_fl(3'd2, 32'h0000_40C0, 1'b0, N'(1) << 3, "R11");
        wr(3'd0, 32'd9);
        wr_fl(3'd2, 32'h0000_0000, 1'b0, '0, "R11");

        // R5: lowest matching index wins
        cur_req = "R5";
        wr(3'd0, 32'd1);
        wr(3'd4, 32'd0);
        wr(3'd1, 32'd0);
        wr(3'd2, 32'h0000_40C0);
        wr(3'd4, 32'h0000_0022);
        srch(32'h0000_4123); rd(3'd0, 32'd1, "R5");

        // R13: one busy cycle, accesses during it dropped
        cur_req = "R13";
        wr(3'd0, 32'd7);
        @(negedge clk); wr_en = 1; addr = 3'd3; wdata = 32'h0000_4000;
        @(negedge clk); addr = 3'd0; wdata = 32'h55;
        check(busy == 1, "R13", "busy after search", 64'(busy), 64'd1);
        @(negedge clk); wr_en = 0;
        check(busy == 0, "R13", "busy second cycle", 64'(busy), 64'd0);
        rd(3'd0, 32'd1, "R13");

        // R12: access levels
        cur_req = "R12";
        cfg_access = 2'd1;
        wr(3'd4, 32'h33); rd(3'd4, 32'h22, "R12");
        wr(3'd5, 32'h1);  rd(3'd5, 32'hC000_0000, "R12");
        wr(3'd3, 32'h0000_8000);
        check(busy == 0, "R12", "search ignored", 64'(busy), 64'd0);
        cfg_access = 2'd2;
        rd(3'd4, 32'd0, "R12"); rd(3'd2, 32'd0, "R12");
        rd(3'd0, 32'd1, "R12");
        wr(3'd4, 32'h44);
        cfg_access = 2'd3;
        rd(3'd4, 32'h44, "R12");
        cfg_mmu = 2'd1;
        rd(3'd0, 32'd0, "R12");
        wr(3'd0, 32'd7);
        cfg_mmu = 2'd3;
        rd(3'd0, 32'd1, "R12");

        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule